// File: doc/BRIEF.md
# Audio Master Clock Divider

This block produces the serial audio bit clock and the left/right frame clock from a master clock when the audio port runs as the clock source. A two-bit mode code stands for a three-level strap and picks one of three cases. In the first, the port is a follower and the block drives nothing. In the second, the master clock runs at 384 times the sample rate. In the third, it runs at 256 times the sample rate. The bit clock is always 64 times the frame clock, so each half frame, one per channel, is 32 bit clocks long.

The divider runs on the master clock and has a synchronous reset. The frame clock only ever changes together with a falling bit clock edge. A change of mode code does not take effect at once. It waits for the next frame start, so no frame is ever cut short or stretched. The block also takes the sample-rate band strap as an input. That strap only labels the sample-rate range and has no effect on division. The output-enable goes to the pad cells, and the pads tri-state both clocks whenever the block is idle.

Top module: `aclk_master_div`

## Requirements
- R1: With mode code 2'b00 (follower) the output-enable is 0 and both clock outputs are held at 0.
- R2: With mode code 2'b01 (384fs) the bit clock period is 6 master clock cycles: 3 low, then 3 high.
- R3: With mode code 2'b10 (256fs) the bit clock period is 4 master clock cycles: 2 low, then 2 high.
- R4: The frame clock changes only in the cycle in which the bit clock falls.
- R5: Each frame clock level lasts exactly 32 bit clock periods, so the bit clock is 64 times the frame clock.
- R6: After reset, or when clocking starts from idle, the output-enable rises one cycle after a master mode code is seen. The first falling bit clock edge then opens a frame with the frame clock low. That low half still lasts 32 further falls.
- R7: A change between the two ratio codes takes effect only at a frame start, on the falling edge that returns the frame clock low. The old period holds until then.
- R8: A change from a ratio code to 2'b00 also waits for a frame start, where all outputs drop to 0. A change from 2'b00 to a ratio code starts clocking on the next cycle.
- R9: The sample-rate band input has no effect on any output.
- R10: The unused mode code 2'b11 behaves exactly like 2'b00.
- R11: While reset is asserted, the output-enable, bit clock and frame clock are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; clocks all logic |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Mode code: 00 follower, 01 ratio 384, 10 ratio 256, 11 follower |
| osr_band | input | 1 | Sample-rate band strap; informational only |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| clk_oe | output | 1 | Output-enable for the clock pads |

## Verification
On every cycle, the assertions check four things. Both clocks are low while idle. The frame clock moves only on a falling bit clock. Every bit clock level lasts half of the active divisor. Every frame clock level spans 32 falling edges. They also check that the active ratio changes only at a frame start, and that clocking starts one cycle after a master code appears. Only the bench's scenarios show the mapping from each mode code to its divisor. The same goes for the deferral of a code change to the exact frame start, the null effect of the band strap, and the follower behaviour of the reserved code. The bench compares every output on every cycle against waveforms it computes from cycle counts.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   typedef enum logic [1:0] {
      SEL_FOLLOW = 2'b00,
      SEL_WIDE   = 2'b01,
      SEL_NARROW = 2'b10,
      SEL_RSVD   = 2'b11
   } ratio_sel_e;

   function automatic logic sel_drives(input logic [1:0] code);
      return (ratio_sel_e'(code) == SEL_WIDE) || (ratio_sel_e'(code) == SEL_NARROW);
   endfunction

endpackage

// File: rtl/aclk_ratio_ctl.sv
module aclk_ratio_ctl
   import aclk_pkg::*;
#(
   parameter int DIV_WIDE   = 6,
   parameter int DIV_NARROW = 4,
   parameter int CW         = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    sel,
   input  logic          frame_edge,
   output logic          run,
   output logic [CW-1:0] div
);

   logic [CW-1:0] div_req;

   always_comb begin
      if (ratio_sel_e'(sel) == SEL_WIDE) div_req = CW'(DIV_WIDE);
      else                               div_req = CW'(DIV_NARROW);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run <= 1'b0;
         div <= CW'(DIV_NARROW);
      end else if (!run || frame_edge) begin
         run <= sel_drives(sel);
         div <= div_req;
      end
   end

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic [CW-1:0] div,
   output logic          bclk,
   output logic          fall
);

   logic [CW-1:0] dcnt;
   logic [CW-1:0] dnxt;
   logic          at_last;

   assign at_last = (dcnt == div - CW'(1));
   assign dnxt    = at_last ? '0 : dcnt + CW'(1);
   assign fall    = run && at_last;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         dcnt <= '0;
         bclk <= 1'b0;
      end else begin
         dcnt <= dnxt;
         bclk <= (dnxt >= (div >> 1));
      end
   end

endmodule

// File: rtl/aclk_frame_cnt.sv
module aclk_frame_cnt #(
   parameter int SLOT_BCLKS = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic fall,
   output logic lrclk,
   output logic frame_edge
);

   localparam int FRAME = 2 * SLOT_BCLKS;
   localparam int BW    = $clog2(FRAME);

   logic          primed;
   logic [BW-1:0] bcnt;
   logic [BW-1:0] bnxt;
   logic          at_end;

   assign at_end     = (bcnt == BW'(FRAME - 1));
   assign frame_edge = fall && (!primed || at_end);
   assign bnxt       = !primed ? '0 : (at_end ? '0 : bcnt + BW'(1));

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         primed <= 1'b0;
         bcnt   <= '0;
         lrclk  <= 1'b0;
      end else if (fall) begin
         primed <= 1'b1;
         bcnt   <= bnxt;
         lrclk  <= (bnxt >= BW'(SLOT_BCLKS));
      end
   end

endmodule

// File: rtl/aclk_master_div.sv
module aclk_master_div #(
   parameter int DIV_WIDE   = 6,
   parameter int DIV_NARROW = 4,
   parameter int SLOT_BCLKS = 32
) (
   input  logic       mclk,
   input  logic       rst,
   input  logic [1:0] mode_sel,
   input  logic       osr_band,
   output logic       bclk_o,
   output logic       lrclk_o,
   output logic       clk_oe
);

   localparam int DIV_MAX = (DIV_WIDE > DIV_NARROW) ? DIV_WIDE : DIV_NARROW;
   localparam int CW      = $clog2(DIV_MAX + 1);

   generate
      if (DIV_WIDE < 2 || (DIV_WIDE % 2) != 0) begin : g_bad_wide
         $error("DIV_WIDE must be even and at least 2");
      end
      if (DIV_NARROW < 2 || (DIV_NARROW % 2) != 0) begin : g_bad_narrow
         $error("DIV_NARROW must be even and at least 2");
      end
      if (SLOT_BCLKS < 1) begin : g_bad_slot
         $error("SLOT_BCLKS must be positive");
      end
   endgenerate

   logic          band_unused;
   logic          run;
   logic [CW-1:0] act_div;
   logic          fall;
   logic          frame_edge;

   assign band_unused = osr_band;

   aclk_ratio_ctl #(
      .DIV_WIDE  (DIV_WIDE),
      .DIV_NARROW(DIV_NARROW),
      .CW        (CW)
   ) i_ratio (
      .clk       (mclk),
      .rst       (rst),
      .sel       (mode_sel),
      .frame_edge(frame_edge),
      .run       (run),
      .div       (act_div)
   );

   aclk_bit_div #(
      .CW(CW)
   ) i_bdiv (
      .clk (mclk),
      .rst (rst),
      .run (run),
      .div (act_div),
      .bclk(bclk_o),
      .fall(fall)
   );

   aclk_frame_cnt #(
      .SLOT_BCLKS(SLOT_BCLKS)
   ) i_frame (
      .clk       (mclk),
      .rst       (rst),
      .run       (run),
      .fall      (fall),
      .lrclk     (lrclk_o),
      .frame_edge(frame_edge)
   );

   assign clk_oe = run;

endmodule

// File: rtl/aclk_master_div_chk.sv
module aclk_master_div_chk
   import aclk_pkg::*;
#(
   parameter int SLOT_BCLKS = 32,
   parameter int CW         = 3
) (
   input logic          mclk,
   input logic          rst,
   input logic [1:0]    mode_sel,
   input logic          bclk,
   input logic          lrclk,
   input logic          oe,
   input logic [CW-1:0] div
);

   localparam int FW = $clog2(SLOT_BCLKS) + 1;

   logic          bclk_d;
   logic          lr_d;
   logic [CW-1:0] run_len;
   logic [FW-1:0] fall_cnt;

   always_ff @(posedge mclk) begin
      bclk_d <= bclk;
      lr_d   <= lrclk;
      if (rst || !oe) run_len <= '0;
      else if (bclk != bclk_d) run_len <= CW'(1);
      else run_len <= run_len + CW'(1);
      if (rst || !oe) fall_cnt <= '1;
      else if (bclk_d && !bclk) begin
         if (lrclk != lr_d) fall_cnt <= '0;
         else fall_cnt <= fall_cnt + FW'(1);
      end
   end

   p_idle_quiet_r1: assert property (@(posedge mclk) disable iff (rst)
      !oe |-> (!bclk && !lrclk));

   // R2 and R3: each bit clock level lasts half the active divisor
   p_half_period_r2: assert property (@(posedge mclk) disable iff (rst)
      (oe && $past(oe) && bclk != $past(bclk)) |-> (run_len == ($past(div) >> 1)));

   p_lr_on_fall_r4: assert property (@(posedge mclk) disable iff (rst)
      (lrclk != $past(lrclk)) |-> ($past(bclk) && !bclk));

   p_slot_len_r5: assert property (@(posedge mclk) disable iff (rst)
      (oe && $past(oe) && lrclk != $past(lrclk)) |-> (fall_cnt == FW'(SLOT_BCLKS - 1)));

   p_start_next_r6: assert property (@(posedge mclk) disable iff (rst)
      ($past(!rst) && $past(!oe) && $past(sel_drives(mode_sel))) |-> oe);

   p_ratio_at_frame_r7: assert property (@(posedge mclk) disable iff (rst)
      ($past(oe) && oe && div != $past(div)) |-> ($past(bclk) && !bclk && !lrclk));

endmodule

bind aclk_master_div aclk_master_div_chk #(
   .SLOT_BCLKS(SLOT_BCLKS),
   .CW        (CW)
) i_chk (
   .mclk    (mclk),
   .rst     (rst),
   .mode_sel(mode_sel),
   .bclk    (bclk_o),
   .lrclk   (lrclk_o),
   .oe      (clk_oe),
   .div     (act_div)
);

// File: tb/test_aclk_master_div.sv
module test_aclk_master_div;

   localparam int SLOT  = 32;
   localparam int FRAME = 2 * SLOT;

   logic       mclk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic       osr_band = 1'b0;
   logic       bclk_o;
   logic       lrclk_o;
   logic       clk_oe;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 mclk = ~mclk;

   aclk_master_div i_aclk_master_div (
      .mclk    (mclk),
      .rst     (rst),
      .mode_sel(mode_sel),
      .osr_band(osr_band),
      .bclk_o  (bclk_o),
      .lrclk_o (lrclk_o),
      .clk_oe  (clk_oe)
   );

   // expected {bclk, lrclk} for cycle nrel (>=1) after clocking starts
   function automatic logic [1:0] fresh(input int d, input int nrel);
      int m = nrel - 1;
      int f = m / d;
      int b = (f >= 1) ? (f - 1) % FRAME : 0;
      return {logic'((m % d) >= d / 2), logic'(b >= SLOT)};
   endfunction

   // expected {bclk, lrclk} mrel cycles after a frame start
   function automatic logic [1:0] cont(input int d, input int mrel);
      int f = mrel / d;
      return {logic'((mrel % d) >= d / 2), logic'((f % FRAME) >= SLOT)};
   endfunction

   task automatic cmp(input string tag, input logic [2:0] exp);
      logic [2:0] act = {clk_oe, bclk_o, lrclk_o};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: oe/bclk/lrclk got %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic step();
      @(posedge mclk);
      @(negedge mclk);
   endtask

   task automatic start(input logic [1:0] sel, input logic band);
      @(negedge mclk);
      rst = 1'b1;
      mode_sel = sel;
      osr_band = band;
      repeat (3) step();
      cmp("R11 reset", 3'b000);
      rst = 1'b0;
   endtask

   initial begin
      // R2 R5 R6: ratio 384 from reset, beyond one full frame
      start(2'b01, 1'b0);
      for (int n = 1; n <= 6 * 66 + 1; n++) begin
         step();
         cmp("R2 R5 R6", {1'b1, fresh(6, n)});
      end

      // R3 R5 R6: ratio 256 from reset
      start(2'b10, 1'b0);
      for (int n = 1; n <= 4 * 66 + 1; n++) begin
         step();
         cmp("R3 R5 R6", {1'b1, fresh(4, n)});
      end

      // R9: band strap high gives the identical waveform
      start(2'b10, 1'b1);
      for (int n = 1; n <= 4 * 66 + 1; n++) begin
         step();
         cmp("R9", {1'b1, fresh(4, n)});
      end

      // R1: follower code keeps everything low
      start(2'b00, 1'b0);
      for (int n = 1; n <= 100; n++) begin
         step();
         cmp("R1", 3'b000);
      end

      // R10: reserved code behaves as follower
      start(2'b11, 1'b1);
      for (int n = 1; n <= 100; n++) begin
         step();
         cmp("R10", 3'b000);
      end

      // R7: 384 -> 256 requested mid frame, applied at frame start (cycle 391)
      start(2'b01, 1'b0);
      for (int n = 1; n <= 100; n++) begin
         step();
         cmp("R7 before", {1'b1, fresh(6, n)});
      end
      mode_sel = 2'b10;
      for (int n = 101; n <= 391; n++) begin
         step();
         cmp("R7 held", {1'b1, fresh(6, n)});
      end
      for (int k = 1; k <= 4 * 70; k++) begin
         step();
         cmp("R7 after", {1'b1, cont(4, k)});
      end

      // R8: 256 -> follower waits for frame start (cycle 261), then restart
      start(2'b10, 1'b0);
      for (int n = 1; n <= 50; n++) begin
         step();
         cmp("R8 run", {1'b1, fresh(4, n)});
      end
      mode_sel = 2'b00;
      for (int n = 51; n <= 260; n++) begin
         step();
         cmp("R8 held", {1'b1, fresh(4, n)});
      end
      for (int n = 261; n <= 300; n++) begin
         step();
         cmp("R8 idle", 3'b000);
      end
      mode_sel = 2'b01;
      for (int n = 301; n <= 301 + 6 * 40; n++) begin
         step();
         cmp("R8 restart", {1'b1, fresh(6, n - 300)});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge mclk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule